// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block takes interrupt messages from a system bus and parks each one in a mailbox slot that belongs to the CPU the message targets. Each message names a target CPU and a source ID, and carries two data words. Every CPU owns exactly one slot. A slot holds a busy flag, the source ID and both data words. A message is taken only when its target slot is free. The bus sender gets an accept or reject answer in the same cycle it presents the message. A refused message is not queued, and the sender is expected to try again later.

When a message is taken, the block posts an interrupt to the target CPU one cycle later. Every such interrupt carries the same vector, which comes from a single programmable register. Software reads a slot either by its index or through alias addresses. An alias address resolves to the slot of the CPU that issues the access. Software frees a slot by clearing its busy bit. Register reads return their data one cycle after the request.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset every slot is not busy, with source ID and both data words zero. The shared vector is zero. No interrupt is posted and no read response is pending.
- R2: A message whose target slot is free gets `msg_ack` high in the same cycle. From the next cycle the slot is busy and holds the message's source ID and both data words.
- R3: A message whose target slot is busy gets `msg_nack` high in the same cycle and leaves the slot unchanged. A target CPU number of NCPU or above is always refused.
- R4: One cycle after a message is taken, `irq_post` pulses for one cycle. `irq_cpu` carries the target CPU and `irq_vec` carries the shared vector as it stood in the acceptance cycle.
- R5: The shared vector register sits at address 0x318 and keeps write data bits 5:0. Upper write bits are dropped, and a read returns the 6-bit value zero-extended.
- R6: A busy-register read returns the busy flag in bit 5 and the source ID in bits 4:0, with all other bits zero.
- R7: A write to a busy register loads bit 5 of the write data into the busy flag. Clearing it frees the slot for the next message, and setting it makes the slot refuse messages. The stored source ID is kept in both cases.
- R8: Indexed registers for slot i sit at 8-byte strides. Data word 0 is at 0x000+8i, data word 1 is at 0x100+8i, and busy is at 0x200+8i.
- R9: Alias addresses select the slot of the accessing CPU given on `reg_cpu`. Data word 0 is at 0x300, data word 1 at 0x308, and busy at 0x310.
- R10: If a busy-clear write and a message for the same slot fall in one cycle, the clear applies first and the message is taken.
- R11: Every read request gets `reg_rvalid` with its data in the following cycle. Misaligned addresses, unmapped addresses and slot indexes of NCPU or above read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Bus message present this cycle |
| msg_cpu | input | CPU_W | Target CPU of the message |
| msg_src | input | SRC_W | Source ID of the message |
| msg_d0 | input | DATA_W | Message data word 0 |
| msg_d1 | input | DATA_W | Message data word 1 |
| msg_ack | output | 1 | Message taken (combinational) |
| msg_nack | output | 1 | Message refused, retry later (combinational) |
| irq_post | output | 1 | Interrupt post pulse |
| irq_cpu | output | CPU_W | CPU the interrupt is posted to |
| irq_vec | output | VEC_W | Vector of the posted interrupt |
| reg_en | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte address of the register |
| reg_cpu | input | CPU_W | Identity of the accessing CPU, used by the alias addresses |
| reg_wdata | input | DATA_W | Write data |
| reg_rvalid | output | 1 | Read response valid |
| reg_rdata | output | DATA_W | Read response data |

## Verification
A stuck or wrongly set busy flag shows up at the ports in the very cycle the next message for that CPU arrives: `msg_ack` and `msg_nack` swap, and then an `irq_post` is missing or extra one cycle later. Corrupted latched source or data only becomes visible when software reads the slot, so the bench follows every acceptance with indexed and alias reads of the same slot. A wrong vector register appears on `irq_vec` at the next acceptance. A slot-decode fault appears as read data from a neighbouring slot, which the bench catches by keeping distinct contents in several slots.

// File: rtl/bus_irq_mailbox.sv
module bus_irq_mailbox #(
  parameter int NCPU   = 6,
  parameter int SRC_W  = 5,
  parameter int DATA_W = 64,
  parameter int VEC_W  = 6,
  localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [CPU_W-1:0]  msg_cpu,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [DATA_W-1:0] msg_d0,
  input  logic [DATA_W-1:0] msg_d1,
  output logic              msg_ack,
  output logic              msg_nack,
  output logic              irq_post,
  output logic [CPU_W-1:0]  irq_cpu,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [9:0]        reg_addr,
  input  logic [CPU_W-1:0]  reg_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int NSLOT    = 1 << CPU_W;
  localparam int BUSY_BIT = 5;
  localparam logic [CPU_W:0] NCPU_C = (CPU_W+1)'(NCPU);

  typedef enum logic [2:0] {K_NONE, K_D0, K_D1, K_BZ, K_VEC} kind_t;

  logic [NSLOT-1:0]  busy_q;
  logic [NSLOT-1:0]  busy_eff;
  logic [SRC_W-1:0]  src_q [NSLOT];
  logic [DATA_W-1:0] d0_q  [NSLOT];
  logic [DATA_W-1:0] d1_q  [NSLOT];
  logic [VEC_W-1:0]  vec_q;

  kind_t            kind;
  logic [CPU_W-1:0] slot;
  logic [4:0]       idx;
  logic             idx_ok, alias_ok;
  logic             bz_wr, vec_wr;

  assign idx      = reg_addr[7:3];
  assign idx_ok   = {1'b0, idx} < 6'(NCPU);
  assign alias_ok = {1'b0, reg_cpu} < NCPU_C;

  always_comb begin
    kind = K_NONE;
    slot = '0;
    if (reg_addr[2:0] == 3'd0) begin
      case (reg_addr[9:8])
        2'd0: if (idx_ok) begin kind = K_D0; slot = idx[CPU_W-1:0]; end
        2'd1: if (idx_ok) begin kind = K_D1; slot = idx[CPU_W-1:0]; end
        2'd2: if (idx_ok) begin kind = K_BZ; slot = idx[CPU_W-1:0]; end
        default: begin
          case (idx)
            5'd0: if (alias_ok) begin kind = K_D0; slot = reg_cpu; end
            5'd1: if (alias_ok) begin kind = K_D1; slot = reg_cpu; end
            5'd2: if (alias_ok) begin kind = K_BZ; slot = reg_cpu; end
            5'd3: kind = K_VEC;
            default: kind = K_NONE;
          endcase
        end
      endcase
    end
  end

  assign bz_wr  = reg_en && reg_wr && (kind == K_BZ);
  assign vec_wr = reg_en && reg_wr && (kind == K_VEC);

  assign msg_ack  = msg_valid && !busy_eff[msg_cpu];
  assign msg_nack = msg_valid && busy_eff[msg_cpu];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < NCPU) begin : g_real
      logic              wr_hit, take;
      logic              bz_r;
      logic [SRC_W-1:0]  src_r;
      logic [DATA_W-1:0] d0_r, d1_r;

      assign wr_hit      = bz_wr && (slot == CPU_W'(i));
      assign busy_eff[i] = wr_hit ? reg_wdata[BUSY_BIT] : bz_r;
      assign take        = msg_ack && (msg_cpu == CPU_W'(i));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          bz_r  <= 1'b0;
          src_r <= '0;
          d0_r  <= '0;
          d1_r  <= '0;
        end else if (take) begin
          bz_r  <= 1'b1;
          src_r <= msg_src;
          d0_r  <= msg_d0;
          d1_r  <= msg_d1;
        end else if (wr_hit) begin
          bz_r  <= reg_wdata[BUSY_BIT];
        end
      end

      assign busy_q[i] = bz_r;
      assign src_q[i]  = src_r;
      assign d0_q[i]   = d0_r;
      assign d1_q[i]   = d1_r;
    end else begin : g_pad
      assign busy_eff[i] = 1'b1;
      assign busy_q[i]   = 1'b0;
      assign src_q[i]    = '0;
      assign d0_q[i]     = '0;
      assign d1_q[i]     = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= '0;
    else if (vec_wr) vec_q <= reg_wdata[VEC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_post <= 1'b0;
      irq_cpu  <= '0;
      irq_vec  <= '0;
    end else begin
      irq_post <= msg_ack;
      irq_cpu  <= msg_cpu;
      irq_vec  <= vec_q;
    end
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (kind)
      K_D0:  rd_mux = d0_q[slot];
      K_D1:  rd_mux = d1_q[slot];
      K_BZ: begin
        rd_mux[BUSY_BIT]  = busy_q[slot];
        rd_mux[SRC_W-1:0] = src_q[slot];
      end
      K_VEC: rd_mux[VEC_W-1:0] = vec_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_en && !reg_wr;
      reg_rdata  <= (reg_en && !reg_wr) ? rd_mux : '0;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[DATA_W-1:VEC_W];

  // R4
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack |=> irq_post && (irq_cpu == $past(msg_cpu)));

  // R3
  no_irq_on_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_nack && !msg_ack) |=> !irq_post);

  // R2
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ack |=> busy_q[$past(msg_cpu)]);

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_wr |=> $stable(vec_q));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_wr) |=> reg_rvalid);

endmodule

// File: tb/bus_irq_mailbox_tb.sv
`timescale 1ns/1ps
module bus_irq_mailbox_tb;
  localparam int NCPU   = 6;
  localparam int SRC_W  = 5;
  localparam int DATA_W = 64;
  localparam int VEC_W  = 6;
  localparam int CPU_W  = $clog2(NCPU);

  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic              msg_valid = 0;
  logic [CPU_W-1:0]  msg_cpu = '0;
  logic [SRC_W-1:0]  msg_src = '0;
  logic [DATA_W-1:0] msg_d0 = '0, msg_d1 = '0;
  logic              msg_ack, msg_nack, irq_post;
  logic [CPU_W-1:0]  irq_cpu;
  logic [VEC_W-1:0]  irq_vec;
  logic              reg_en = 0, reg_wr = 0;
  logic [9:0]        reg_addr = '0;
  logic [CPU_W-1:0]  reg_cpu = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic              reg_rvalid;
  logic [DATA_W-1:0] reg_rdata;

  bus_irq_mailbox #(.NCPU(NCPU), .SRC_W(SRC_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_cpu(msg_cpu), .msg_src(msg_src),
    .msg_d0(msg_d0), .msg_d1(msg_d1), .msg_ack(msg_ack), .msg_nack(msg_nack),
    .irq_post(irq_post), .irq_cpu(irq_cpu), .irq_vec(irq_vec),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_cpu(reg_cpu),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit              m_busy [NCPU];
  logic [SRC_W-1:0]  m_src [NCPU];
  logic [DATA_W-1:0] m_d0 [NCPU];
  logic [DATA_W-1:0] m_d1 [NCPU];
  logic [VEC_W-1:0]  m_vec;

  logic [DATA_W-1:0] rd_q[$];
  string             rd_tag[$];
  logic [CPU_W+VEC_W-1:0] irq_q[$];
  string             irq_tag[$];

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void dec(input logic [9:0] a, input int rc, output int k, output int s);
    int idx;
    k = 0; s = 0;
    idx = int'(a[7:3]);
    if (a[2:0] != 3'd0) return;
    case (a[9:8])
      2'd0: begin k = 1; s = idx; end
      2'd1: begin k = 2; s = idx; end
      2'd2: begin k = 3; s = idx; end
      default: case (idx)
        0: begin k = 1; s = rc; end
        1: begin k = 2; s = rc; end
        2: begin k = 3; s = rc; end
        3: k = 4;
        default: k = 0;
      endcase
    endcase
    if (k >= 1 && k <= 3 && s >= NCPU) k = 0;
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic [9:0] a, input int rc);
    int k, s;
    logic [DATA_W-1:0] v;
    dec(a, rc, k, s);
    v = '0;
    case (k)
      1: v = m_d0[s];
      2: v = m_d1[s];
      3: begin v[5] = m_busy[s]; v[SRC_W-1:0] = m_src[s]; end
      4: v[VEC_W-1:0] = m_vec;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic drive(input bit mv, input int mc, input logic [SRC_W-1:0] ms,
                       input logic [DATA_W-1:0] d0, input logic [DATA_W-1:0] d1,
                       input bit re, input bit rw, input logic [9:0] a, input int rc,
                       input logic [DATA_W-1:0] wd, input string tag);
    int k, s;
    bit b, acc;
    @(negedge clk);
    msg_valid = mv; msg_cpu = CPU_W'(mc); msg_src = ms; msg_d0 = d0; msg_d1 = d1;
    reg_en = re; reg_wr = rw; reg_addr = a; reg_cpu = CPU_W'(rc); reg_wdata = wd;
    #1;
    if (re && !rw) begin
      rd_q.push_back(exp_read(a, rc));
      rd_tag.push_back(tag);
    end
    dec(a, rc, k, s);
    acc = 0;
    if (mv) begin
      if (mc < NCPU) begin
        b = m_busy[mc];
        if (re && rw && k == 3 && s == mc) b = wd[5];
        acc = !b;
      end
    end
    chk(DATA_W'(msg_ack), DATA_W'(acc), {tag, " ack"});
    chk(DATA_W'(msg_nack), DATA_W'(mv && !acc), {tag, " nack"});
    if (acc) begin
      irq_q.push_back({CPU_W'(mc), m_vec});
      irq_tag.push_back(tag);
    end
    if (re && rw) begin
      if (k == 3) m_busy[s] = wd[5];
      if (k == 4) m_vec = wd[VEC_W-1:0];
    end
    if (acc) begin
      m_busy[mc] = 1; m_src[mc] = ms; m_d0[mc] = d0; m_d1[mc] = d1;
    end
    @(posedge clk);
    #1;
    msg_valid = 0; reg_en = 0; reg_wr = 0;
  endtask

  task automatic send(input int mc, input logic [SRC_W-1:0] ms, input logic [DATA_W-1:0] d0,
                      input logic [DATA_W-1:0] d1, input string tag);
    drive(1, mc, ms, d0, d1, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic rd(input logic [9:0] a, input int rc, input string tag);
    drive(0, 0, '0, '0, '0, 1, 0, a, rc, '0, tag);
  endtask

  task automatic wr(input logic [9:0] a, input int rc, input logic [DATA_W-1:0] wd, input string tag);
    drive(0, 0, '0, '0, '0, 1, 1, a, rc, wd, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_rvalid) begin
        if (rd_q.size() == 0) chk(reg_rdata, 64'hDEAD, "R11 unexpected read response");
        else chk(reg_rdata, rd_q.pop_front(), rd_tag.pop_front());
      end
      if (irq_post) begin
        if (irq_q.size() == 0) chk({irq_cpu, irq_vec}, '1, "R4 unexpected irq");
        else chk(DATA_W'({irq_cpu, irq_vec}), DATA_W'(irq_q.pop_front()), irq_tag.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NCPU; i++) begin
      m_busy[i] = 0; m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
    end
    m_vec = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(DATA_W'(irq_post), 0, "R1 irq idle");
    chk(DATA_W'(reg_rvalid), 0, "R1 no read pending");
    for (int i = 0; i < NCPU; i++) rd(10'h200 + 10'(8*i), 0, "R1 busy clear at reset");
    rd(10'h318, 0, "R1 vector zero");
    rd(10'h010, 0, "R1 data0 zero");
    rd(10'h128, 0, "R1 data1 zero");

    wr(10'h318, 0, 64'hFFFF_FFFF_FFFF_FFEA, "R5 vector write");
    rd(10'h318, 0, "R5 vector keeps 6 bits");

    send(2, 5'h13, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, "R2 R4 accept cpu2");
    rd(10'h210, 0, "R6 busy format slot2");
    rd(10'h010, 0, "R8 data0 slot2");
    rd(10'h110, 0, "R8 data1 slot2");
    send(3, 5'h07, 64'h5, 64'h6, "R2 accept cpu3");
    rd(10'h018, 0, "R8 data0 slot3 distinct");

    send(2, 5'h01, 64'h99, 64'h98, "R3 refuse busy cpu2");
    rd(10'h010, 0, "R3 data0 unchanged");
    rd(10'h210, 0, "R3 source unchanged");
    send(6, 5'h02, 64'h1, 64'h2, "R3 refuse cpu6 out of range");
    send(7, 5'h02, 64'h1, 64'h2, "R3 refuse cpu7 out of range");

    rd(10'h300, 2, "R9 alias data0 cpu2");
    rd(10'h308, 2, "R9 alias data1 cpu2");
    rd(10'h310, 2, "R9 alias busy cpu2");
    rd(10'h310, 4, "R9 alias busy cpu4");
    rd(10'h300, 3, "R9 alias data0 cpu3");

    wr(10'h210, 0, 64'h0, "R7 clear slot2");
    rd(10'h210, 0, "R7 cleared keeps source");
    send(2, 5'h0A, 64'h7777, 64'h8888, "R7 accept after clear");
    rd(10'h210, 0, "R7 new source latched");

    drive(1, 2, 5'h15, 64'hABCD, 64'hDCBA, 1, 1, 10'h310, 2, 64'h0, "R10 clear and message same cycle");
    rd(10'h300, 2, "R10 new data0 latched");

    wr(10'h220, 0, 64'h20, "R7 set busy slot4");
    send(4, 5'h03, 64'h1, 64'h1, "R7 refuse set slot4");
    rd(10'h220, 0, "R7 slot4 busy src zero");

    wr(10'h318, 0, 64'h15, "R4 vector change");
    send(5, 5'h1F, 64'hF0F0, 64'h0F0F, "R4 irq with new vector");

    rd(10'h204, 0, "R11 misaligned reads zero");
    rd(10'h320, 0, "R11 unmapped reads zero");
    rd(10'h230, 0, "R11 index out of range reads zero");
    rd(10'h300, 7, "R11 alias out of range reads zero");

    repeat (4) @(negedge clk);
    chk(DATA_W'(rd_q.size()), 0, "R11 all reads answered");
    chk(DATA_W'(irq_q.size()), 0, "R4 all irqs posted");
    finish_run();
  end
endmodule